// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches page table entries so that a virtual page number becomes a physical frame number in the same cycle as the request. Every entry stores a page number, a frame number, four permission and status flags, and the id of the process that owns it. A lookup hits only when the page number matches and the entry's process id equals the current-process register. No page table walk is done inside the block. A miss is reported on its own output, and the requester then either walks the table or raises a fault.

A refill agent writes entries through the insert port. The slot is chosen in hardware. An entry already holding the same page for the current process is rewritten first. Otherwise the lowest-numbered empty slot is used. If no slot is empty, a round-robin pointer picks the slot. There are two ways to invalidate on a context switch. A flush empties every slot. A valid-clear drops only the valid flag and leaves the rest of each entry in place.

Top module: `tagged_tlb`

## Requirements
- R1: With `lkValid` high, `lkHit`, `lkFrame` and `lkFlags` reflect the stored entry in the same cycle, with no register on the path. The flags field is {dirty, referenced, writable, valid} in bits 3..0.
- R2: A lookup hits only when an occupied entry's page equals `lkPage` and its process tag equals the current-process register. That register is reset to 0. A `pidLoad` takes effect from the next cycle. Inserts are tagged with the register value at the time of the insert.
- R3: `lkMiss` is high exactly when `lkValid` is high and no entry hits. Both `lkHit` and `lkMiss` are low when `lkValid` is low. After reset every lookup misses.
- R4: `flushAll` empties every entry, so all later lookups miss until new inserts arrive.
- R5: `clearValid` clears only bit 0 (valid) of every entry. A later lookup of a cached page still hits and returns the same frame and the other three flags, with valid at 0.
- R6: An insert that matches no existing entry goes to the lowest-index empty slot if one exists.
- R7: When every slot is occupied, a new insert replaces the slot named by a round-robin pointer. The pointer resets to 0 and advances by one, modulo the entry count, on every accepted insert.
- R8: An insert whose page and current process id match an occupied entry overwrites that entry, and no duplicate is created.
- R9: A lookup in the same cycle as an insert returns the contents from before the insert.
- R10: At most one entry matches any lookup.
- R11: `flushAll` overrides an insert in the same cycle. An insert in the same cycle as `clearValid` keeps the flags it was given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pidLoad | input | 1 | Load the current-process register |
| pidIn | input | 8 | New current process id |
| lkValid | input | 1 | Lookup request |
| lkPage | input | 11 | Page number to translate |
| lkHit | output | 1 | Lookup hit |
| lkMiss | output | 1 | Lookup miss |
| lkFrame | output | 19 | Frame number of the hitting entry |
| lkFlags | output | 4 | {dirty, referenced, writable, valid} of the hitting entry |
| insValid | input | 1 | Insert (refill) request |
| insPage | input | 11 | Page number to insert |
| insFrame | input | 19 | Frame number to insert |
| insFlags | input | 4 | Flags to insert |
| flushAll | input | 1 | Empty all entries |
| clearValid | input | 1 | Clear the valid flag of all entries |

## Verification
The bench builds the block with 4 entries instead of 64. With so few slots, a handful of inserts fills the buffer, so round-robin eviction, pointer wrap-around and the rewrite of a matching entry in a full buffer all come up many times in the random phase. Pages are drawn from a set of six and process ids from a set of three. This makes cross-process aliasing of one page number common, and it exercises the tag compare in both directions.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_W     = 11;
  localparam int FRAME_W    = 19;
  localparam int PID_W      = 8;
  localparam int FLAG_W     = 4;
  localparam int FLAG_VALID = 0;

  typedef struct packed {
    logic wrEn;
    logic clrValid;
    logic flush;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insValid,
  input  logic               flushAll,
  input  logic               clearValid,
  input  logic [ENTRIES-1:0] insMatch,
  input  logic [ENTRIES-1:0] freeVec,
  output tlbStrobe_t         stb,
  output logic [IDX_W-1:0]   wrIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             matchAny;
  logic             freeAny;

  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (insMatch[i]) matchIdx = IDX_W'(i);
      if (freeVec[i])  freeIdx  = IDX_W'(i);
    end
    matchAny = |insMatch;
    freeAny  = |freeVec;
    wrIdx    = matchAny ? matchIdx : (freeAny ? freeIdx : rrPtr);
    stb.flush    = flushAll;
    stb.clrValid = clearValid & ~flushAll;
    stb.wrEn     = insValid & ~flushAll;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr <= '0;
    end else if (stb.wrEn) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  // R6: a fresh insert lands on an empty slot whenever one exists
  a_r6_prefer_free: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrEn && !matchAny && freeAny) |-> freeVec[wrIdx]);

  // R8: a matching insert never targets a slot other than the matching one
  a_r8_overwrite_match: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrEn && matchAny) |-> insMatch[wrIdx]);

  // R7: the pointer moves only when an insert is accepted
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wrEn |=> $stable(rrPtr));
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PG_W    = PAGE_W,
  parameter int FR_W    = FRAME_W,
  parameter int ID_W    = PID_W,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tlbStrobe_t         stb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               pidLoad,
  input  logic [ID_W-1:0]    pidIn,
  input  logic               lkValid,
  input  logic [PG_W-1:0]    lkPage,
  output logic               lkHit,
  output logic               lkMiss,
  output logic [FR_W-1:0]    lkFrame,
  output logic [FLAG_W-1:0]  lkFlags,
  input  logic [PG_W-1:0]    insPage,
  input  logic [FR_W-1:0]    insFrame,
  input  logic [FLAG_W-1:0]  insFlags,
  output logic [ENTRIES-1:0] insMatch,
  output logic [ENTRIES-1:0] freeVec
);
  logic [ENTRIES-1:0] occ;
  logic [PG_W-1:0]    pageArr  [ENTRIES];
  logic [ID_W-1:0]    pidArr   [ENTRIES];
  logic [FR_W-1:0]    frameArr [ENTRIES];
  logic [FLAG_W-1:0]  flagArr  [ENTRIES];
  logic [ID_W-1:0]    curPid;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] validVec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lkMatch[g]  = occ[g] && (pageArr[g] == lkPage)  && (pidArr[g] == curPid);
    assign insMatch[g] = occ[g] && (pageArr[g] == insPage) && (pidArr[g] == curPid);
    assign freeVec[g]  = ~occ[g];
    assign validVec[g] = occ[g] & flagArr[g][FLAG_VALID];
  end

  always_comb begin
    lkFrame = '0;
    lkFlags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) begin
        lkFrame = lkFrame | frameArr[i];
        lkFlags = lkFlags | flagArr[i];
      end
    end
    lkHit  = lkValid & (|lkMatch);
    lkMiss = lkValid & ~(|lkMatch);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curPid <= '0;
    end else if (pidLoad) begin
      curPid <= pidIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pageArr[i]  <= '0;
        pidArr[i]   <= '0;
        frameArr[i] <= '0;
        flagArr[i]  <= '0;
      end
    end else if (stb.flush) begin
      occ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (stb.wrEn && (wrIdx == IDX_W'(i))) begin
          occ[i]      <= 1'b1;
          pageArr[i]  <= insPage;
          pidArr[i]   <= curPid;
          frameArr[i] <= insFrame;
          flagArr[i]  <= insFlags;
        end else if (stb.clrValid) begin
          flagArr[i][FLAG_VALID] <= 1'b0;
        end
      end
    end
  end

  // R10: the compare never finds two owners for one page
  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkMatch));

  // R4: a flush leaves no occupied slot behind
  a_r4_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    stb.flush |=> (occ == '0));

  // R5: a valid-clear without a concurrent insert leaves no valid entry
  a_r5_valid_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clrValid && !stb.wrEn) |=> (validVec == '0));

  // R2: the process register takes the loaded value one cycle later
  a_r2_pid_load: assert property (@(posedge clk) disable iff (!rst_n)
    pidLoad |=> (curPid == $past(pidIn)));
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PG_W    = PAGE_W,
  parameter int FR_W    = FRAME_W,
  parameter int ID_W    = PID_W,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pidLoad,
  input  logic [ID_W-1:0]   pidIn,
  input  logic              lkValid,
  input  logic [PG_W-1:0]   lkPage,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [FR_W-1:0]   lkFrame,
  output logic [FLAG_W-1:0] lkFlags,
  input  logic              insValid,
  input  logic [PG_W-1:0]   insPage,
  input  logic [FR_W-1:0]   insFrame,
  input  logic [FLAG_W-1:0] insFlags,
  input  logic              flushAll,
  input  logic              clearValid
);
  tlbStrobe_t         stb;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] insMatch;
  logic [ENTRIES-1:0] freeVec;

  tlb_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .insValid(insValid), .flushAll(flushAll),
    .clearValid(clearValid), .insMatch(insMatch), .freeVec(freeVec),
    .stb(stb), .wrIdx(wrIdx)
  );

  tlb_datapath #(.ENTRIES(ENTRIES), .PG_W(PG_W), .FR_W(FR_W), .ID_W(ID_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrIdx(wrIdx),
    .pidLoad(pidLoad), .pidIn(pidIn),
    .lkValid(lkValid), .lkPage(lkPage), .lkHit(lkHit), .lkMiss(lkMiss),
    .lkFrame(lkFrame), .lkFlags(lkFlags),
    .insPage(insPage), .insFrame(insFrame), .insFlags(insFlags),
    .insMatch(insMatch), .freeVec(freeVec)
  );

  // R3: hit and miss are exclusive and only raised for a real request
  a_r3_hit_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lkHit || lkMiss) |-> (lkValid && (lkHit != lkMiss)));
endmodule

// File: tb/tagged_tlb_tb.sv
`timescale 1ns/1ps
module tagged_tlb_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pidLoad = 1'b0;
  logic [7:0]  pidIn = '0;
  logic        lkValid = 1'b0;
  logic [10:0] lkPage = '0;
  logic        lkHit, lkMiss;
  logic [18:0] lkFrame;
  logic [3:0]  lkFlags;
  logic        insValid = 1'b0;
  logic [10:0] insPage = '0;
  logic [18:0] insFrame = '0;
  logic [3:0]  insFlags = '0;
  logic        flushAll = 1'b0;
  logic        clearValid = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  tagged_tlb #(.ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pidLoad(pidLoad), .pidIn(pidIn),
    .lkValid(lkValid), .lkPage(lkPage), .lkHit(lkHit), .lkMiss(lkMiss),
    .lkFrame(lkFrame), .lkFlags(lkFlags),
    .insValid(insValid), .insPage(insPage), .insFrame(insFrame), .insFlags(insFlags),
    .flushAll(flushAll), .clearValid(clearValid)
  );

  // reference state, built from the requirements
  bit          mOcc   [N];
  logic [10:0] mPage  [N];
  logic [7:0]  mPid   [N];
  logic [18:0] mFrame [N];
  logic [3:0]  mFlags [N];
  int          mRr;
  logic [7:0]  mCur;

  function automatic int findEntry(logic [10:0] pg);
    for (int i = 0; i < N; i++)
      if (mOcc[i] && mPage[i] == pg && mPid[i] == mCur) return i;
    return -1;
  endfunction

  function automatic int pickSlot(logic [10:0] pg);
    int m = findEntry(pg);
    if (m >= 0) return m;
    for (int i = 0; i < N; i++) if (!mOcc[i]) return i;
    return mRr;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit lv, logic [10:0] lp,
                      bit iv, logic [10:0] ip, logic [18:0] ifr, logic [3:0] ifl,
                      bit pl, logic [7:0] pv, bit fl, bit cv);
    int e, s;
    @(negedge clk);
    lkValid = lv; lkPage = lp; insValid = iv; insPage = ip; insFrame = ifr;
    insFlags = ifl; pidLoad = pl; pidIn = pv; flushAll = fl; clearValid = cv;
    #1;
    e = findEntry(lp);
    check({tag, " hit"},  {31'd0, lkHit},  {31'd0, lv && e >= 0});
    check({tag, " miss"}, {31'd0, lkMiss}, {31'd0, lv && e < 0});
    if (lv && e >= 0) begin
      check({tag, " frame"}, {13'd0, lkFrame}, {13'd0, mFrame[e]});
      check({tag, " flags"}, {28'd0, lkFlags}, {28'd0, mFlags[e]});
    end
    if (fl) begin
      for (int i = 0; i < N; i++) mOcc[i] = 0;
    end else begin
      s = iv ? pickSlot(ip) : -1;
      for (int i = 0; i < N; i++) begin
        if (i == s) begin
          mOcc[i] = 1; mPage[i] = ip; mPid[i] = mCur; mFrame[i] = ifr; mFlags[i] = ifl;
        end else if (cv) mFlags[i][0] = 1'b0;
      end
      if (iv) mRr = (mRr + 1) % N;
    end
    if (pl) mCur = pv;
  endtask

  task automatic look(string tag, logic [10:0] pg);
    step(tag, 1, pg, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic put(string tag, logic [10:0] pg, logic [18:0] fr, logic [3:0] f);
    step(tag, 0, 0, 1, pg, fr, f, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mOcc[i] = 0; mPage[i] = 0; mPid[i] = 0; mFrame[i] = 0; mFlags[i] = 0;
    end
    mRr = 0; mCur = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    look("R3 reset miss", 11'd1);
    step("R9 lookup during insert", 1, 11'd1, 1, 11'd1, 19'd100, 4'b0011, 0, 0, 0, 0);
    look("R1 hit after insert", 11'd1);
    step("R2 pid load not yet seen", 1, 11'd1, 0, 0, 0, 0, 1, 8'd5, 0, 0);
    look("R2 other process misses", 11'd1);
    step("R2 back to pid 0", 0, 0, 0, 0, 0, 0, 1, 8'd0, 0, 0);
    look("R2 own process hits", 11'd1);
    put("R6 fill", 11'd2, 19'd200, 4'b0001);
    put("R6 fill", 11'd3, 19'd300, 4'b1111);
    put("R6 fill", 11'd4, 19'd400, 4'b0101);
    put("R8 rewrite present page", 11'd1, 19'd111, 4'b0111);
    look("R8 rewritten frame", 11'd1);
    for (int p = 2; p <= 4; p++) look("R8 no duplicate eviction", 11'(p));
    put("R7 evict by pointer", 11'd5, 19'd500, 4'b0011);
    for (int p = 1; p <= 5; p++) look("R7 survivor check", 11'(p));
    step("R11 insert with clear", 0, 0, 1, 11'd6, 19'd600, 4'b0011, 0, 0, 0, 1);
    look("R5 valid cleared, frame kept", 11'd1);
    look("R11 new entry keeps valid", 11'd6);
    step("R11 flush beats insert", 0, 0, 1, 11'd7, 19'd700, 4'b0011, 0, 0, 1, 0);
    look("R4 flushed page misses", 11'd1);
    look("R11 dropped insert misses", 11'd7);
    for (int p = 8; p <= 11; p++) put("R6 refill after flush", 11'(p), 19'(p * 3), 4'b0001);
    for (int p = 8; p <= 11; p++) look("R6 all free slots used", 11'(p));

    for (int k = 0; k < 3000; k++) begin
      bit lv = ($urandom % 4) != 0;
      bit iv = ($urandom % 3) == 0;
      bit pl = ($urandom % 16) == 0;
      bit fl = ($urandom % 64) == 0;
      bit cv = ($urandom % 32) == 0;
      step("R1/R2/R3/R7/R8/R10 random", lv, 11'($urandom % 6), iv, 11'($urandom % 6),
           19'($urandom), 4'($urandom), pl, 8'($urandom % 3), fl, cv);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
  end
endmodule